// File: doc/BRIEF.md
# Flash Soft Block Lock Controller

This block decodes bus write cycles for a small NOR-style flash built from a parameterised number of blocks (eight by default) and keeps one volatile soft protection bit per block. Software locks or unlocks blocks with two-cycle commands. The first cycle carries the protection opcode and the second carries an action code: lock one block, unlock one block, lock all blocks or unlock all blocks. The block index is taken from the top address bits of that second cycle.

The soft bits are combined with a write-protect pin, an active-low reset pin and a digital "programming voltage too low" flag. The result is a per-block write-permit vector that the program and erase logic outside this block consults. A status command lets software read the lock state of any block. The status word, driven while the bus reads in status mode, carries that lock state in bit 1.

Top module: `soft_lock_ctrl`

## Requirements
- R1: A write cycle is captured only on a rising edge of `we_n` while `ce_n` is low. A `we_n` pulse with `ce_n` high changes no lock bit and no mode.
- R2: First-cycle code 0x0F followed by second-cycle code 0x01 locks the block selected by `addr[ADDR_W-1 -: log2(NBLK)]`. Code 0xD0 unlocks only that block. Both leave the controller in status mode with that block selected.
- R3: After 0x0F, second-cycle code 0x02 locks every block and 0xD1 unlocks every block.
- R4: After 0x0F, any other second-cycle code leaves every lock bit unchanged and returns to array-read mode, where `dout_en` stays 0.
- R5: `rst` high, or `rp_n` low, sets every lock bit and returns to array-read mode.
- R6: With `rp_n` high and `vpp_low` low, `wr_ok[i]` is 0 exactly when block i is locked and `wp_n` is low. With `wp_n` high, every `wr_ok` bit is 1.
- R7: While `vpp_low` is high, every `wr_ok` bit is 0 and write cycles are ignored, so lock bits and mode stay as they were.
- R8: First-cycle code 0x70 followed by any second cycle enters status mode for the block addressed in that second cycle. In status mode, with `ce_n` and `oe_n` low, `dout_en` is 1 and `dout` holds bit 7 = 1 (ready), bit 1 = lock state, and all other bits 0. In status mode, a first-cycle code other than 0x0F or 0x70 returns to array-read mode.
- R9: Status bit 1 reads 0 whenever `wp_n` is high, whatever the soft bit holds.
- R10: While `rp_n` is low, every `wr_ok` bit is 0.
- R11: A block that was unlocked while `wp_n` was high stays writable after `wp_n` goes low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous power-up reset, active high |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low; cycle captured on its rising edge |
| oe_n | input | 1 | Output enable, active low |
| rp_n | input | 1 | Reset pin, active low |
| wp_n | input | 1 | Write-protect pin; low lets soft bits take effect |
| vpp_low | input | 1 | Programming voltage below lockout level |
| addr | input | ADDR_W | Word address; top bits select the block |
| din | input | DATA_W | Write data; low byte is the command code |
| dout | output | DATA_W | Status word in status mode, zero otherwise |
| dout_en | output | 1 | High when `dout` is being driven |
| wr_ok | output | NBLK | Per-block write permit |

## Verification
The assertions take the strobes to be synchronous to `clk` and take a write pulse to hold `we_n` low for at least one full clock. They also take `ce_n` to stay low through the clock that sees the rising edge. The bench therefore changes every pin only on the falling clock edge, keeps `ce_n` low from one cycle before the `we_n` pulse until one cycle after it, and draws its random code values from a weighted set that includes illegal action codes. Pin toggles of `wp_n`, `rp_n` and `vpp_low` happen only between whole write cycles.

// File: rtl/slc_pkg.sv
package slc_pkg;

    localparam logic [7:0] OP_PROTECT = 8'h0F;
    localparam logic [7:0] OP_STATUS  = 8'h70;
    localparam logic [7:0] ACT_SET1   = 8'h01;
    localparam logic [7:0] ACT_CLR1   = 8'hD0;
    localparam logic [7:0] ACT_SETALL = 8'h02;
    localparam logic [7:0] ACT_CLRALL = 8'hD1;
    localparam int         SR_READY   = 7;
    localparam int         SR_LOCKED  = 1;

    typedef enum logic [1:0] {
        M_ARRAY  = 2'd0,
        M_LOCK2  = 2'd1,
        M_STAT2  = 2'd2,
        M_STATUS = 2'd3
    } mode_e;

    typedef enum logic [2:0] {
        LK_NONE   = 3'd0,
        LK_SET1   = 3'd1,
        LK_CLR1   = 3'd2,
        LK_SETALL = 3'd3,
        LK_CLRALL = 3'd4
    } lk_kind_e;

    function automatic lk_kind_e decode_action(input logic [7:0] code);
        case (code)
            ACT_SET1:   return LK_SET1;
            ACT_CLR1:   return LK_CLR1;
            ACT_SETALL: return LK_SETALL;
            ACT_CLRALL: return LK_CLRALL;
            default:    return LK_NONE;
        endcase
    endfunction

    function automatic mode_e first_cycle(input logic [7:0] code);
        case (code)
            OP_PROTECT: return M_LOCK2;
            OP_STATUS:  return M_STAT2;
            default:    return M_ARRAY;
        endcase
    endfunction

endpackage

// File: rtl/slc_wr_detect.sv
module slc_wr_detect (
    input  logic clk,
    input  logic rst,
    input  logic ce_n,
    input  logic we_n,
    input  logic accept,
    output logic stb
);
    logic we_q;

    always_ff @(posedge clk) begin
        if (rst) we_q <= 1'b1;
        else     we_q <= we_n;
    end

    assign stb = we_n & ~we_q & ~ce_n & accept;
endmodule

// File: rtl/slc_cmd_fsm.sv
module slc_cmd_fsm
    import slc_pkg::*;
#(
    parameter int BLK_W = 3
) (
    input  logic             clk,
    input  logic             clr,
    input  logic             stb,
    input  logic [7:0]       code,
    input  logic [BLK_W-1:0] blk,
    output mode_e            mode,
    output logic [BLK_W-1:0] sel,
    output lk_kind_e         lk_kind
);
    mode_e            mode_q;
    logic [BLK_W-1:0] sel_q;
    lk_kind_e         act;

    assign act     = decode_action(code);
    assign lk_kind = (stb && mode_q == M_LOCK2) ? act : LK_NONE;
    assign mode    = mode_q;
    assign sel     = sel_q;

    always_ff @(posedge clk) begin
        if (clr) begin
            mode_q <= M_ARRAY;
            sel_q  <= '0;
        end else if (stb) begin
            case (mode_q)
                M_LOCK2: begin
                    if (act != LK_NONE) begin
                        mode_q <= M_STATUS;
                        sel_q  <= blk;
                    end else begin
                        mode_q <= M_ARRAY;
                    end
                end
                M_STAT2: begin
                    mode_q <= M_STATUS;
                    sel_q  <= blk;
                end
                default: mode_q <= first_cycle(code);
            endcase
        end
    end
endmodule

// File: rtl/slc_lock_bank.sv
module slc_lock_bank
    import slc_pkg::*;
#(
    parameter int NBLK  = 8,
    parameter int BLK_W = 3
) (
    input  logic             clk,
    input  logic             clr,
    input  lk_kind_e         lk_kind,
    input  logic [BLK_W-1:0] blk,
    input  logic             wp_n,
    input  logic             rp_n,
    input  logic             vpp_low,
    output logic [NBLK-1:0]  lock_q,
    output logic [NBLK-1:0]  wr_ok
);
    for (genvar i = 0; i < NBLK; i++) begin : g_blk
        logic hit;
        assign hit = (blk == BLK_W'(i));

        always_ff @(posedge clk) begin
            if (clr) begin
                lock_q[i] <= 1'b1;
            end else begin
                case (lk_kind)
                    LK_SETALL: lock_q[i] <= 1'b1;
                    LK_CLRALL: lock_q[i] <= 1'b0;
                    LK_SET1:   if (hit) lock_q[i] <= 1'b1;
                    LK_CLR1:   if (hit) lock_q[i] <= 1'b0;
                    default:   ;
                endcase
            end
        end

        assign wr_ok[i] = rp_n & ~vpp_low & ~(lock_q[i] & ~wp_n);
    end
endmodule

// File: rtl/soft_lock_ctrl.sv
module soft_lock_ctrl
    import slc_pkg::*;
#(
    parameter int NBLK   = 8,
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic              rp_n,
    input  logic              wp_n,
    input  logic              vpp_low,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en,
    output logic [NBLK-1:0]   wr_ok
);
    localparam int BLK_W = (NBLK > 1) ? $clog2(NBLK) : 1;

    logic             clr;
    logic             stb;
    logic [BLK_W-1:0] blk;
    logic [BLK_W-1:0] sel;
    mode_e            mode;
    lk_kind_e         lk_kind;
    logic [NBLK-1:0]  lock_q;

    assign clr = rst | ~rp_n;
    assign blk = addr[ADDR_W-1 -: BLK_W];

    slc_wr_detect u_wr (
        .clk    (clk),
        .rst    (rst),
        .ce_n   (ce_n),
        .we_n   (we_n),
        .accept (rp_n & ~vpp_low),
        .stb    (stb)
    );

    slc_cmd_fsm #(.BLK_W(BLK_W)) u_fsm (
        .clk     (clk),
        .clr     (clr),
        .stb     (stb),
        .code    (din[7:0]),
        .blk     (blk),
        .mode    (mode),
        .sel     (sel),
        .lk_kind (lk_kind)
    );

    slc_lock_bank #(.NBLK(NBLK), .BLK_W(BLK_W)) u_bank (
        .clk     (clk),
        .clr     (clr),
        .lk_kind (lk_kind),
        .blk     (blk),
        .wp_n    (wp_n),
        .rp_n    (rp_n),
        .vpp_low (vpp_low),
        .lock_q  (lock_q),
        .wr_ok   (wr_ok)
    );

    always_comb begin
        dout    = '0;
        dout_en = 1'b0;
        if (mode == M_STATUS && !ce_n && !oe_n && rp_n) begin
            dout_en             = 1'b1;
            dout[SR_READY]      = 1'b1;
            dout[SR_LOCKED]     = lock_q[sel] & ~wp_n;
        end
    end
endmodule

// File: rtl/slc_checker.sv
module slc_checker #(
    parameter int NBLK   = 8,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              ce_n,
    input logic              rp_n,
    input logic              wp_n,
    input logic              vpp_low,
    input logic [DATA_W-1:0] dout,
    input logic              dout_en,
    input logic [NBLK-1:0]   wr_ok,
    input logic [NBLK-1:0]   lock_q
);
    assert_reset_locks_R5: assert property (@(posedge clk) disable iff (rst)
        !rp_n |=> (lock_q == {NBLK{1'b1}}));

    assert_wp_high_open_R6: assert property (@(posedge clk) disable iff (rst)
        (wp_n && rp_n && !vpp_low) |-> (wr_ok == {NBLK{1'b1}}));

    assert_vpp_blocks_R7: assert property (@(posedge clk) disable iff (rst)
        vpp_low |-> (wr_ok == '0));

    assert_vpp_freeze_R7: assert property (@(posedge clk) disable iff (rst)
        (vpp_low && rp_n) |=> $stable(lock_q));

    assert_no_cs_no_write_R1: assert property (@(posedge clk) disable iff (rst)
        (ce_n && rp_n) |=> $stable(lock_q));

    assert_sr1_masked_R9: assert property (@(posedge clk) disable iff (rst)
        (dout_en && wp_n) |-> !dout[1]);

    assert_rp_blocks_R10: assert property (@(posedge clk) disable iff (rst)
        !rp_n |-> (wr_ok == '0));
endmodule

bind soft_lock_ctrl slc_checker #(.NBLK(NBLK), .DATA_W(DATA_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .ce_n    (ce_n),
    .rp_n    (rp_n),
    .wp_n    (wp_n),
    .vpp_low (vpp_low),
    .dout    (dout),
    .dout_en (dout_en),
    .wr_ok   (wr_ok),
    .lock_q  (lock_q)
);

// File: tb/sim_soft_lock_ctrl.sv
module sim_soft_lock_ctrl;
    localparam int NBLK = 8, ADDR_W = 20, DATA_W = 16;

    logic clk = 0, rst = 1, ce_n = 1, we_n = 1, oe_n = 1;
    logic rp_n = 1, wp_n = 0, vpp_low = 0;
    logic [ADDR_W-1:0] addr = '0;
    logic [DATA_W-1:0] din = '0;
    logic [DATA_W-1:0] dout;
    logic dout_en;
    logic [NBLK-1:0] wr_ok;

    int total = 0, bad = 0;
    logic [NBLK-1:0] m_lock;
    int m_mode;   // 0 array, 1 lock2, 2 stat2, 3 status
    int m_sel;

    always #5 clk = ~clk;

    soft_lock_ctrl #(.NBLK(NBLK), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u0 (
        .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .rp_n(rp_n), .wp_n(wp_n), .vpp_low(vpp_low), .addr(addr),
        .din(din), .dout(dout), .dout_en(dout_en), .wr_ok(wr_ok)
    );

    function automatic logic [NBLK-1:0] exp_ok();
        if (!rp_n || vpp_low) return '0;
        return ~(m_lock & {NBLK{~wp_n}});
    endfunction

    function automatic logic [DATA_W-1:0] exp_status();
        logic [DATA_W-1:0] w = '0;
        w[7] = 1'b1;
        w[1] = m_lock[m_sel] & ~wp_n;
        return w;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_lock = '1; m_mode = 0; m_sel = 0;
    endtask

    task automatic model_wr(input logic [ADDR_W-1:0] a, input logic [7:0] c);
        int b = int'(a[ADDR_W-1 -: 3]);
        case (m_mode)
            1: begin
                case (c)
                    8'h01: begin m_lock[b] = 1'b1; m_mode = 3; m_sel = b; end
                    8'hD0: begin m_lock[b] = 1'b0; m_mode = 3; m_sel = b; end
                    8'h02: begin m_lock = '1; m_mode = 3; m_sel = b; end
                    8'hD1: begin m_lock = '0; m_mode = 3; m_sel = b; end
                    default: m_mode = 0;
                endcase
            end
            2: begin m_mode = 3; m_sel = b; end
            default: m_mode = (c == 8'h0F) ? 1 : (c == 8'h70) ? 2 : 0;
        endcase
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [7:0] c, input logic cs);
        @(negedge clk); ce_n = ~cs; addr = a; din = {8'h00, c};
        @(negedge clk); we_n = 0;
        @(negedge clk); we_n = 1;
        @(negedge clk); ce_n = 1;
        if (cs && rp_n && !vpp_low) model_wr(a, c);
    endtask

    function automatic logic [ADDR_W-1:0] baddr(input int b);
        return {3'(b), 17'($urandom)};
    endfunction

    task automatic check_all(input string tag);
        @(negedge clk); ce_n = 0; oe_n = 0;
        #1;
        chk({tag, " wr_ok"}, 32'(wr_ok), 32'(exp_ok()));
        chk({tag, " dout_en"}, 32'(dout_en), 32'(m_mode == 3 && rp_n));
        chk({tag, " dout"}, 32'(dout), (m_mode == 3 && rp_n) ? 32'(exp_status()) : 32'h0);
        @(negedge clk); ce_n = 1; oe_n = 1;
    endtask

    task automatic pulse_rp();
        @(negedge clk); rp_n = 0; model_reset();
        #1; chk("R10 wr_ok during rp_n", 32'(wr_ok), 32'h0);
        @(negedge clk); @(negedge clk); rp_n = 1;
    endtask

    initial begin
        #2000000;
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        model_reset();
        repeat (3) @(negedge clk);
        rst = 0;
        check_all("R5 reset");

        wr(baddr(3), 8'h0F, 1); wr(baddr(3), 8'hD0, 1);
        check_all("R2 clear one");
        wr(baddr(5), 8'h0F, 1); wr(baddr(5), 8'hD0, 1);
        wr(baddr(3), 8'h0F, 1); wr(baddr(3), 8'h01, 1);
        check_all("R2 set one");
        wr(baddr(0), 8'h0F, 1); wr(baddr(0), 8'h33, 1);
        check_all("R4 abort");
        wr(baddr(0), 8'h0F, 1); wr(baddr(2), 8'hD1, 1);
        check_all("R3 clear all");
        wr(baddr(0), 8'h0F, 1); wr(baddr(6), 8'h02, 1);
        check_all("R3 set all");
        wr(baddr(4), 8'h0F, 0); wr(baddr(4), 8'hD0, 0);
        wp_n = 0; check_all("R1 no chip enable");
        wp_n = 1; check_all("R6 wp high");
        wr(baddr(0), 8'h70, 1); wr(baddr(2), 8'hFF, 1);
        check_all("R9 sr1 masked");
        wr(baddr(2), 8'h0F, 1); wr(baddr(2), 8'hD0, 1);
        wp_n = 0; check_all("R11 cleared stays open");
        wr(baddr(2), 8'h70, 1); wr(baddr(1), 8'h00, 1);
        check_all("R8 status read");
        wr(baddr(0), 8'hFF, 1);
        check_all("R8 back to array");
        vpp_low = 1;
        wr(baddr(1), 8'h0F, 1); wr(baddr(1), 8'hD0, 1);
        check_all("R7 vpp low");
        vpp_low = 0;
        wr(baddr(1), 8'h70, 1); wr(baddr(1), 8'h00, 1);
        check_all("R7 bits kept");
        pulse_rp();
        check_all("R5 rp pulse");

        for (int n = 0; n < 400; n++) begin
            int r = int'($urandom_range(0, 99));
            logic [7:0] c;
            case ($urandom_range(0, 7))
                0: c = 8'h0F; 1: c = 8'h70; 2: c = 8'h01; 3: c = 8'hD0;
                4: c = 8'h02; 5: c = 8'hD1; 6: c = 8'hFF;
                default: c = 8'($urandom);
            endcase
            if (r < 6) wp_n = ~wp_n;
            else if (r < 9) vpp_low = ~vpp_low;
            else if (r < 11) pulse_rp();
            wr(baddr(int'($urandom_range(0, NBLK-1))), c, ($urandom_range(0, 9) != 0));
            if (n % 2 == 1) check_all("R6 R8 random");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule